// File: doc/BRIEF.md
# Pipelined Crossbar Epoch Allocator

This block decides, once per epoch, which source port of a point-to-point switch may send to which destination port. Each source presents a vector of the destinations it wants. Each destination can hold off new traffic with an inhibit line. The allocator produces a one-to-one pairing. No destination is used twice, no source sends twice, and no inhibited destination is chosen. Sources flagged at build time as forwarding-engine ports are matched before the ordinary line-card ports.

The schedule is pipelined over four epochs and a new request set is accepted every epoch. In epoch N a source raises its request, and the allocator samples it on the last tick of that epoch. The allocator computes the pairing during epoch N+1. In epoch N+2 the pairing is shown on the notify outputs, so both ends can configure. In epoch N+3 the same pairing is shown on the transfer outputs while the data moves. Fixed low-index priority would be unfair, so a 16-bit LFSR rotates the order in which sources and destinations are scanned. The LFSR advances once per epoch, and the source order and the destination order are rotated independently.

Top module: `xbar_epoch_alloc`

## Requirements
- R1: An epoch lasts EPOCH_TICKS clock cycles. `epoch_start_o` is high in the first cycle of each epoch and low otherwise. The first cycle after reset is the first cycle of epoch 0.
- R2: Out of reset, all grant and destination outputs are zero. Notify outputs stay zero during epochs 0 and 1, and transfer outputs stay zero during epochs 0 to 2.
- R3: In any epoch, each destination index is held by at most one granted source, and each source has at most one destination.
- R4: A destination whose bit in `inhibit_i` was sampled high is never paired in the allocation made from that sample.
- R5: A source is only paired with a destination it requested. Bit s*NPORT+d of `req_i` means source s requests destination d.
- R6: A source whose bit in FE_MASK is set is matched before any source whose bit is clear. When a flagged source and an unflagged source contend for the same sole destination, the flagged source wins.
- R7: The shuffle comes from a 16-bit LFSR.
  - Its reset value is SEED.
  - It steps at the last tick of every epoch: next = {v[14:0], v[15]^v[13]^v[12]^v[10]}.
  - During an epoch, the source rotation is v[7:0] mod NPORT and the destination rotation is v[15:8] mod NPORT.
- R8: Allocation is a greedy pass.
  - The pass first covers the flagged sources and then the unflagged sources, each in the order src_rot, src_rot+1, ... (mod NPORT).
  - Each source takes the first destination, in the order dst_rot, dst_rot+1, ... (mod NPORT), that it requested, that is not inhibited and that is not already taken.
- R9: Requests sampled at the end of epoch N are allocated using the LFSR value of epoch N+1. The result appears on the notify outputs throughout epoch N+2 and on the transfer outputs throughout epoch N+3. The outputs change only in the first cycle of an epoch.
- R10: `req_i` and `inhibit_i` are sampled only on the last tick of an epoch. Values present on earlier ticks have no effect.
- R11: Destination fields are packed per source. Source s uses bits [s*DW +: DW], where DW = $clog2(NPORT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NPORT*NPORT | Request matrix; bit s*NPORT+d means source s wants destination d |
| inhibit_i | input | NPORT | Per-destination flow-control hold |
| epoch_start_o | output | 1 | High in the first cycle of each epoch |
| note_grant_o | output | NPORT | Per-source grant, notify epoch |
| note_dest_o | output | NPORT*DW | Per-source destination index, notify epoch |
| xfer_grant_o | output | NPORT | Per-source grant, transfer epoch |
| xfer_dest_o | output | NPORT*DW | Per-source destination index, transfer epoch |

## Verification
A request set presented in epoch e is sampled on that epoch's last tick. It is due on the notify outputs at the first cycle of epoch e+2 and on the transfer outputs at the first cycle of epoch e+3. Each of those results uses the LFSR value of epoch e+1. The bench counts epochs by watching `epoch_start_o` at falling edges. It compares both output stages on the first tick of every epoch and again on the last tick, so a value arriving early or changing mid-epoch is caught. On odd epochs the bench drives decoy requests on the early ticks and the real ones only on the last tick, which shows that only the final tick is sampled.

// File: rtl/xbar_alloc_pkg.sv
package xbar_alloc_pkg;

    localparam int LFSR_W = 16;

    // One step of the shuffle generator (taps 16,14,13,11).
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
        logic fb;
        fb = v[15] ^ v[13] ^ v[12] ^ v[10];
        return {v[14:0], fb};
    endfunction

endpackage

// File: rtl/xbar_epoch_timer.sv
module xbar_epoch_timer #(
    parameter int EPOCH_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic first_o,
    output logic last_o
);
    localparam int TW = (EPOCH_TICKS > 1) ? $clog2(EPOCH_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(EPOCH_TICKS - 1);

    logic [TW-1:0] tick_d, tick_q;

    always_comb begin
        tick_d = (tick_q == LAST) ? '0 : tick_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    assign first_o = (tick_q == '0);
    assign last_o  = (tick_q == LAST);

    assert_tick_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q <= LAST);
endmodule

// File: rtl/xbar_shuffle_lfsr.sv
module xbar_shuffle_lfsr
    import xbar_alloc_pkg::*;
#(
    parameter int               NPORT = 15,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    localparam int              PW = $clog2(NPORT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [PW-1:0] src_rot_o,
    output logic [PW-1:0] dst_rot_o
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = step_i ? lfsr_step(lfsr_q) : lfsr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign src_rot_o = PW'(32'(lfsr_q[7:0])  % NPORT);
    assign dst_rot_o = PW'(32'(lfsr_q[15:8]) % NPORT);

    assert_lfsr_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    assert_lfsr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(lfsr_q));
endmodule

// File: rtl/xbar_greedy_match.sv
module xbar_greedy_match #(
    parameter int             NPORT   = 15,
    parameter logic [NPORT-1:0] FE_MASK = '0,
    localparam int            PW = $clog2(NPORT)
) (
    input  logic [NPORT*NPORT-1:0] req_i,
    input  logic [NPORT-1:0]       inh_i,
    input  logic [PW-1:0]          src_rot_i,
    input  logic [PW-1:0]          dst_rot_i,
    output logic [NPORT-1:0]       grant_o,
    output logic [NPORT*PW-1:0]    dest_o
);
    always_comb begin
        logic [NPORT-1:0] taken;
        int  s;
        int  d;
        logic found;
        taken   = '0;
        grant_o = '0;
        dest_o  = '0;
        s       = 0;
        d       = 0;
        found   = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < NPORT; k++) begin
                s = (int'(src_rot_i) + k) % NPORT;
                if (FE_MASK[s] == (pass == 0)) begin
                    found = 1'b0;
                    for (int j = 0; j < NPORT; j++) begin
                        d = (int'(dst_rot_i) + j) % NPORT;
                        if (!found && req_i[s*NPORT + d] && !inh_i[d] && !taken[d]) begin
                            found                = 1'b1;
                            taken[d]             = 1'b1;
                            grant_o[s]           = 1'b1;
                            dest_o[s*PW +: PW]   = PW'(d);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/xbar_epoch_alloc.sv
module xbar_epoch_alloc
    import xbar_alloc_pkg::*;
#(
    parameter int                NPORT       = 15,
    parameter int                EPOCH_TICKS = 8,
    parameter logic [NPORT-1:0]  FE_MASK     = 15'b000_0000_0000_0011,
    parameter logic [LFSR_W-1:0] SEED        = 16'hACE1,
    localparam int               DW          = $clog2(NPORT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT*NPORT-1:0] req_i,
    input  logic [NPORT-1:0]       inhibit_i,
    output logic                   epoch_start_o,
    output logic [NPORT-1:0]       note_grant_o,
    output logic [NPORT*DW-1:0]    note_dest_o,
    output logic [NPORT-1:0]       xfer_grant_o,
    output logic [NPORT*DW-1:0]    xfer_dest_o
);
    typedef struct packed {
        logic [NPORT*NPORT-1:0] req;
        logic [NPORT-1:0]       inh;
        logic [NPORT-1:0]       note_grant;
        logic [NPORT*DW-1:0]    note_dest;
        logic [NPORT-1:0]       xfer_grant;
        logic [NPORT*DW-1:0]    xfer_dest;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic               ep_first, ep_last;
    logic [DW-1:0]      src_rot, dst_rot;
    logic [NPORT-1:0]   alloc_grant;
    logic [NPORT*DW-1:0] alloc_dest;

    xbar_epoch_timer #(.EPOCH_TICKS(EPOCH_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_o (ep_first),
        .last_o  (ep_last)
    );

    xbar_shuffle_lfsr #(.NPORT(NPORT), .SEED(SEED)) u_shuffle (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (ep_last),
        .src_rot_o (src_rot),
        .dst_rot_o (dst_rot)
    );

    xbar_greedy_match #(.NPORT(NPORT), .FE_MASK(FE_MASK)) u_match (
        .req_i     (pipe_q.req),
        .inh_i     (pipe_q.inh),
        .src_rot_i (src_rot),
        .dst_rot_i (dst_rot),
        .grant_o   (alloc_grant),
        .dest_o    (alloc_dest)
    );

    // All pipeline stages advance together on the last tick of an epoch.
    always_comb begin
        pipe_d = pipe_q;
        if (ep_last) begin
            pipe_d.req        = req_i;
            pipe_d.inh        = inhibit_i;
            pipe_d.note_grant = alloc_grant;
            pipe_d.note_dest  = alloc_dest;
            pipe_d.xfer_grant = pipe_q.note_grant;
            pipe_d.xfer_dest  = pipe_q.note_dest;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign epoch_start_o = ep_first;
    assign note_grant_o  = pipe_q.note_grant;
    assign note_dest_o   = pipe_q.note_dest;
    assign xfer_grant_o  = pipe_q.xfer_grant;
    assign xfer_dest_o   = pipe_q.xfer_dest;

    // ---------------- assertions ----------------
    generate
        for (genvar gd = 0; gd < NPORT; gd++) begin : g_dst_chk
            logic [NPORT-1:0] holders;
            for (genvar gs = 0; gs < NPORT; gs++) begin : g_hold
                assign holders[gs] = pipe_q.note_grant[gs] &&
                                     (pipe_q.note_dest[gs*DW +: DW] == DW'(gd));
            end
            assert_one_to_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(holders));
        end
        for (genvar gs = 0; gs < NPORT; gs++) begin : g_src_chk
            assert_no_inhibited_R4: assert property (@(posedge clk) disable iff (!rst_n)
                alloc_grant[gs] |-> !pipe_q.inh[alloc_dest[gs*DW +: DW]]);
            assert_only_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
                alloc_grant[gs] |-> pipe_q.req[gs*NPORT + int'(alloc_dest[gs*DW +: DW])]);
        end
    endgenerate

    assert_epoch_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_start_o |=> !epoch_start_o);
    assert_hold_in_epoch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_start_o |-> ($stable(xfer_grant_o) && $stable(note_grant_o)));
    assert_stage_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_start_o |-> (xfer_grant_o == $past(note_grant_o)));
endmodule

// File: tb/tb_xbar_epoch_alloc.sv
module tb_xbar_epoch_alloc;
    localparam int N  = 4;
    localparam int T  = 4;
    localparam int DW = 2;
    localparam logic [N-1:0] FE = 4'b0100;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam int NE = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N*N-1:0] req = '0;
    logic [N-1:0]   inh = '0;
    logic           ep_start;
    logic [N-1:0]   ng, xg;
    logic [N*DW-1:0] nd, xd;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    xbar_epoch_alloc #(.NPORT(N), .EPOCH_TICKS(T), .FE_MASK(FE), .SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .inhibit_i(inh),
        .epoch_start_o(ep_start), .note_grant_o(ng), .note_dest_o(nd),
        .xfer_grant_o(xg), .xfer_dest_o(xd)
    );

    logic [N*N-1:0]  st_req [NE];
    logic [N-1:0]    st_inh [NE];
    logic [N-1:0]    ex_g   [NE];
    logic [N*DW-1:0] ex_d   [NE];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Expected allocation from R6/R7/R8.
    task automatic model(input logic [N*N-1:0] r, input logic [N-1:0] ih, input logic [15:0] l,
                         output logic [N-1:0] g, output logic [N*DW-1:0] dd);
        int sr, dr, s, d;
        logic [N-1:0] used;
        logic got;
        sr = int'(l[7:0]) % N;
        dr = int'(l[15:8]) % N;
        used = '0; g = '0; dd = '0;
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < N; k++) begin
                s = (sr + k) % N;
                if (FE[s] == (p == 0)) begin
                    got = 1'b0;
                    for (int j = 0; j < N; j++) begin
                        d = (dr + j) % N;
                        if (!got && r[s*N+d] && !ih[d] && !used[d]) begin
                            got = 1'b1; used[d] = 1'b1; g[s] = 1'b1;
                            dd[s*DW +: DW] = DW'(d);
                        end
                    end
                end
            end
    endtask

    initial begin
        for (int e = 0; e < NE; e++) begin
            logic [31:0] h;
            h = 32'(e) * 32'h9E3779B1;
            st_req[e] = h[23:8] ^ h[31:16];
            st_inh[e] = 4'(e * 7);
            if (e % 5 == 0) st_inh[e] = '0;
        end
        st_req[0] = (16'h1 << (0*N+1)) | (16'h1 << (2*N+1)); st_inh[0] = '0;
        st_req[1] = 16'h8888;                                st_inh[1] = 4'b1000;
        st_req[2] = 16'hFFFF;                                st_inh[2] = '0;
        st_req[3] = '0;                                      st_inh[3] = '0;
    end

    initial begin
        logic [15:0] lf;
        lf = SEED;
        repeat (3) @(negedge clk);
        chk("R2 reset note", 32'(ng), 0);
        chk("R2 reset xfer", 32'(xg), 0);
        chk("R1 start in reset", 32'(ep_start), 1);
        rst_n = 1'b1;
        for (int e = 0; e < NE; e++) begin
            if (e > 0) lf = step(lf);
            chk($sformatf("R1 epoch %0d start", e), 32'(ep_start), 1);
            if (e >= 1) model(st_req[e-1], st_inh[e-1], lf, ex_g[e], ex_d[e]);
            for (int t = 0; t < T; t += T - 1) begin
                if (e >= 2) begin
                    chk($sformatf("R9 R8 note grant e%0d t%0d", e, t), 32'(ng), 32'(ex_g[e-1]));
                    chk($sformatf("R11 R8 note dest e%0d t%0d", e, t), 32'(nd & mask(ng)), 32'(ex_d[e-1]));
                end else
                    chk("R2 note idle", 32'(ng), 0);
                if (e >= 3) begin
                    chk($sformatf("R9 xfer grant e%0d t%0d", e, t), 32'(xg), 32'(ex_g[e-2]));
                    chk($sformatf("R9 xfer dest e%0d t%0d", e, t), 32'(xd & mask(xg)), 32'(ex_d[e-2]));
                end else
                    chk("R2 xfer idle", 32'(xg), 0);
                if (t == 0) begin
                    if (e >= 5 && e % 2 == 1) begin
                        req = ~st_req[e]; inh = ~st_inh[e];   // R10 decoy
                    end else begin
                        req = st_req[e]; inh = st_inh[e];
                    end
                    for (int w = 1; w < T; w++) begin
                        @(negedge clk);
                        chk("R1 no start mid-epoch", 32'(ep_start), 0);
                    end
                    req = st_req[e]; inh = st_inh[e];
                end
            end
            if (e == 2) begin
                chk("R6 FE src2 wins dest1", 32'(ng[2]), 1);
                chk("R6 FE dest value", 32'(nd[2*DW +: DW]), 1);
                chk("R6 line src0 loses", 32'(ng[0]), 0);
            end
            if (e == 3) chk("R4 inhibited dest unused", 32'(ng), 0);
            if (e == 4) chk("R3 R8 full matching", 32'(ng), 32'hF);
            @(negedge clk);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [N*DW-1:0] mask(input logic [N-1:0] g);
        logic [N*DW-1:0] m;
        m = '0;
        for (int s = 0; s < N; s++) if (g[s]) m[s*DW +: DW] = '1;
        return m;
    endfunction

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule